// File: doc/BRIEF.md
# USB Host Interrupt Coalescing Unit

This block gathers the interrupt sources of a USB host controller and drives one interrupt line towards the CPU. Transaction results (a completed transfer whose descriptor asked for an interrupt, or a transaction error) do not reach the status register at once. They wait in a pending stage until the next threshold boundary. A boundary comes once every N micro-frame ticks, where N is a command field. Port-change and host-system-error events go straight into status.

A deferred result is released at a boundary only when the memory write-back of transfer status has finished (`wb_busy` low). When write-back is still busy, the pending result slips to the following boundary. Software reads `sts`, acknowledges bits by writing ones through the clear port, and selects which bits may raise `irq` through the enable register. The active threshold can be read back on `thr`.

Top module: `usb_irq_coalescer`

## Requirements
- R1: After reset, `sts` and `en` are 0, `irq` is low, and `thr` reads 8.
- R2: A `port_chg` pulse sets `sts[2]` and a `sys_err` pulse sets `sts[3]` on the next clock edge, with no deferral. If the bit is enabled, `irq` is high in that same cycle.
- R3: A `xfer_done` pulse with `xfer_ioc` high marks `sts[0]` pending. The bit appears only at the next threshold boundary. A `xfer_done` with `xfer_ioc` low sets nothing.
- R4: An `xfer_err` pulse marks `sts[1]` pending. Like R3, it appears only at the next threshold boundary.
- R5: A threshold boundary falls on every N-th `uf_tick`, where N is the active threshold. After reset N is 8, so the 8th tick is the first boundary.
- R6: A `cmd_wr` write of 1, 2, 4, 8, 16, 32 or 64 to `cmd_thr` sets N to that value. Any other value gives N = 8. `thr` shows the active N from the cycle after the write.
- R7: A pending result is released at a boundary only if `wb_busy` is low in that cycle. Otherwise it stays pending until a later boundary.
- R8: A `clr_wr` write clears each `sts` bit whose `clr_data` bit is 1. Bits written with 0 keep their value.
- R9: If hardware sets a status bit in the same cycle that software clears it, the bit ends up set.
- R10: `irq` is high exactly when some `sts` bit and its matching `en` bit are both 1. A set but disabled bit stays visible in `sts`. `en` is loaded whole by `en_wr`.
- R11: A transaction result that arrives in the cycle of a boundary is not released at that boundary. It waits for the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uf_tick | input | 1 | One pulse per micro-frame |
| xfer_done | input | 1 | A transaction completed successfully |
| xfer_ioc | input | 1 | Descriptor of the completed transfer requests an interrupt |
| xfer_err | input | 1 | A transaction ended in error |
| port_chg | input | 1 | Port change event |
| sys_err | input | 1 | Host system error event |
| wb_busy | input | 1 | Transfer status write-back still in progress |
| cmd_wr | input | 1 | Write strobe for the threshold field |
| cmd_thr | input | 7 | Threshold value in micro-frames |
| en_wr | input | 1 | Write strobe for the enable register |
| en_data | input | 4 | New enable mask |
| clr_wr | input | 1 | Write strobe for status acknowledge |
| clr_data | input | 4 | Ones clear the matching status bits |
| irq | output | 1 | Interrupt line to the CPU |
| sts | output | 4 | Status: [0] transfer done, [1] transfer error, [2] port change, [3] system error |
| en | output | 4 | Enable mask readback |
| thr | output | 7 | Active threshold in micro-frames |

## Verification
Completions are sent without the interrupt flag and with it. The first must leave status untouched, while the second must stay hidden for exactly seven ticks and show on the eighth. Errors are run the same way. A completion is also placed while write-back is busy, which tells a gated boundary apart from an open one, and another lands on the boundary cycle itself, which tells "released now" apart from "released next interval". The threshold is then switched to 2, to the illegal value 3 and to 1. This shows whether the boundary spacing follows the field and whether the fallback to 8 works.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_W   = 4;
  localparam int XFER_W  = 2;
  localparam int B_DONE  = 0;
  localparam int B_ERR   = 1;
  localparam int B_PORT  = 2;
  localparam int B_SYS   = 3;
  typedef logic [SRC_W-1:0]  src_vec_t;
  typedef logic [XFER_W-1:0] xfer_vec_t;
endpackage

// File: rtl/irqc_thr_timer.sv
module irqc_thr_timer #(
  parameter int THR_W   = 7,
  parameter int DEF_THR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [THR_W-1:0] cmd_thr,
  input  logic             uf_tick,
  output logic             boundary,
  output logic [THR_W-1:0] thr_eff
);
  localparam logic [THR_W-1:0] DEF_V = THR_W'(DEF_THR);
  localparam logic [THR_W-1:0] ONE_V = THR_W'(1);

  logic [THR_W-1:0] thr_q, thr_d;
  logic [THR_W-1:0] cnt_q, cnt_d;
  logic             legal;

  always_comb begin
    legal = ($countones(cmd_thr) == 1);
    thr_d = thr_q;
    if (cmd_wr) thr_d = legal ? cmd_thr : DEF_V;
  end

  always_comb begin
    boundary = uf_tick && (cnt_q >= (thr_q - ONE_V));
    cnt_d    = cnt_q;
    if (uf_tick) cnt_d = boundary ? '0 : cnt_q + ONE_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= DEF_V;
      cnt_q <= '0;
    end else begin
      if (cmd_wr)  thr_q <= thr_d;
      if (uf_tick) cnt_q <= cnt_d;
    end
  end

  assign thr_eff = thr_q;
endmodule

// File: rtl/irqc_defer_gate.sv
module irqc_defer_gate
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  xfer_vec_t xfer_new,
  input  logic      boundary,
  input  logic      wb_busy,
  output xfer_vec_t flush
);
  xfer_vec_t pend_q, pend_d;
  logic      open_gate;

  always_comb begin
    open_gate = boundary && !wb_busy;
    flush     = open_gate ? pend_q : '0;
    pend_d    = (pend_q & ~flush) | xfer_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/irqc_status_reg.sv
module irqc_status_reg
  import irqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t hw_set,
  input  logic     clr_wr,
  input  src_vec_t clr_data,
  input  logic     en_wr,
  input  src_vec_t en_data,
  output src_vec_t sts,
  output src_vec_t en,
  output logic     irq
);
  src_vec_t sts_q, sts_d, en_q, clr_mask;

  always_comb begin
    clr_mask = clr_wr ? clr_data : '0;
    sts_d    = (sts_q & ~clr_mask) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      if (en_wr) en_q <= en_data;
    end
  end

  assign sts = sts_q;
  assign en  = en_q;
  assign irq = |(sts_q & en_q);
endmodule

// File: rtl/usb_irq_coalescer.sv
module usb_irq_coalescer
  import irqc_pkg::*;
#(
  parameter int THR_W   = 7,
  parameter int DEF_THR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uf_tick,
  input  logic             xfer_done,
  input  logic             xfer_ioc,
  input  logic             xfer_err,
  input  logic             port_chg,
  input  logic             sys_err,
  input  logic             wb_busy,
  input  logic             cmd_wr,
  input  logic [THR_W-1:0] cmd_thr,
  input  logic             en_wr,
  input  logic [SRC_W-1:0] en_data,
  input  logic             clr_wr,
  input  logic [SRC_W-1:0] clr_data,
  output logic             irq,
  output logic [SRC_W-1:0] sts,
  output logic [SRC_W-1:0] en,
  output logic [THR_W-1:0] thr
);
  logic      rs_meta, rs_n;
  logic      boundary;
  xfer_vec_t xfer_new, flush;
  src_vec_t  hw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  always_comb begin
    xfer_new         = '0;
    xfer_new[B_DONE] = xfer_done && xfer_ioc;
    xfer_new[B_ERR]  = xfer_err;
    hw_set           = '0;
    hw_set[B_DONE]   = flush[B_DONE];
    hw_set[B_ERR]    = flush[B_ERR];
    hw_set[B_PORT]   = port_chg;
    hw_set[B_SYS]    = sys_err;
  end

  irqc_thr_timer #(.THR_W(THR_W), .DEF_THR(DEF_THR)) u_timer (
    .clk(clk), .rst_n(rs_n), .cmd_wr(cmd_wr), .cmd_thr(cmd_thr),
    .uf_tick(uf_tick), .boundary(boundary), .thr_eff(thr)
  );

  irqc_defer_gate u_defer (
    .clk(clk), .rst_n(rs_n), .xfer_new(xfer_new), .boundary(boundary),
    .wb_busy(wb_busy), .flush(flush)
  );

  irqc_status_reg u_status (
    .clk(clk), .rst_n(rs_n), .hw_set(hw_set), .clr_wr(clr_wr),
    .clr_data(clr_data), .en_wr(en_wr), .en_data(en_data),
    .sts(sts), .en(en), .irq(irq)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int THR_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             uf_tick,
  input logic             port_chg,
  input logic             sys_err,
  input logic             wb_busy,
  input logic             clr_wr,
  input logic [SRC_W-1:0] clr_data,
  input logic [SRC_W-1:0] sts,
  input logic [THR_W-1:0] thr
);
  AST_PORT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    port_chg |=> sts[B_PORT]); // R2
  AST_SYS_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err |=> sts[B_SYS]); // R2
  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[B_DONE]) |-> $past(uf_tick)); // R3
  AST_ERR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[B_ERR]) |-> $past(uf_tick)); // R4
  AST_WB_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[B_DONE]) |-> !$past(wb_busy)); // R7
  AST_THR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(thr) == 1); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (port_chg && clr_wr && clr_data[B_PORT]) |=> sts[B_PORT]); // R9

  for (genvar i = 0; i < SRC_W; i++) begin : g_hold
    AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[i] && !(clr_wr && clr_data[i])) |=> sts[i]); // R8
  end
endmodule

bind usb_irq_coalescer irqc_checker #(.THR_W(THR_W)) i_irqc_checker (
  .clk(clk), .rst_n(rst_n), .uf_tick(uf_tick), .port_chg(port_chg),
  .sys_err(sys_err), .wb_busy(wb_busy), .clr_wr(clr_wr), .clr_data(clr_data),
  .sts(sts), .thr(thr)
);

// File: tb/test_usb_irq_coalescer.sv
`timescale 1ns/1ps
module test_usb_irq_coalescer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       uf_tick = 0, xfer_done = 0, xfer_ioc = 0, xfer_err = 0;
  logic       port_chg = 0, sys_err = 0, wb_busy = 0, cmd_wr = 0;
  logic [6:0] cmd_thr = '0;
  logic       en_wr = 0, clr_wr = 0;
  logic [3:0] en_data = '0, clr_data = '0;
  logic       irq;
  logic [3:0] sts, en;
  logic [6:0] thr;

  typedef struct {
    logic [3:0] sts;
    logic       irq;
    logic [3:0] en;
    logic [6:0] thr;
    string      tag;
  } exp_t;

  exp_t       q[$];
  int         n_chk = 0, n_fail = 0;
  logic [3:0] exp_en = '0;
  logic [6:0] exp_thr = 7'd8;
  bit         done = 0;

  always #10 clk = ~clk;

  usb_irq_coalescer i_usb_irq_coalescer (
    .clk(clk), .rst_n(rst_n), .uf_tick(uf_tick), .xfer_done(xfer_done),
    .xfer_ioc(xfer_ioc), .xfer_err(xfer_err), .port_chg(port_chg),
    .sys_err(sys_err), .wb_busy(wb_busy), .cmd_wr(cmd_wr), .cmd_thr(cmd_thr),
    .en_wr(en_wr), .en_data(en_data), .clr_wr(clr_wr), .clr_data(clr_data),
    .irq(irq), .sts(sts), .en(en), .thr(thr)
  );

  // Monitor: compares 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        n_chk++;
        if (sts !== it.sts || irq !== it.irq || en !== it.en || thr !== it.thr) begin
          n_fail++;
          $display("FAIL %s: sts=%h irq=%b en=%h thr=%0d expected sts=%h irq=%b en=%h thr=%0d",
                   it.tag, sts, irq, en, thr, it.sts, it.irq, it.en, it.thr);
        end
      end
    end
  end

  // Driver: inputs already set at a falling edge; optionally push expectation
  task automatic step(input bit chk, input logic [3:0] es, input logic ei, input string tag);
    exp_t it;
    if (chk) begin
      it.sts = es; it.irq = ei; it.en = exp_en; it.thr = exp_thr; it.tag = tag;
      q.push_back(it);
    end
    @(negedge clk);
    uf_tick = 0; xfer_done = 0; xfer_ioc = 0; xfer_err = 0;
    port_chg = 0; sys_err = 0; cmd_wr = 0; en_wr = 0; clr_wr = 0;
  endtask

  task automatic ticks(input int n, input logic [3:0] es, input logic ei, input string tag);
    for (int i = 0; i < n; i++) begin
      uf_tick = 1;
      step(1, es, ei, tag);
    end
  endtask

  task automatic clear(input logic [3:0] m, input logic [3:0] es, input logic ei, input string tag);
    clr_wr = 1; clr_data = m;
    step(1, es, ei, tag);
  endtask

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    step(1, 4'h0, 0, "R1 reset state");

    en_wr = 1; en_data = 4'hF; exp_en = 4'hF;
    step(1, 4'h0, 0, "R10 enable load");

    port_chg = 1; step(1, 4'h4, 1, "R2 port change immediate");
    clear(4'h4, 4'h0, 0, "R8 clear port bit");
    sys_err = 1;  step(1, 4'h8, 1, "R2 system error immediate");
    clear(4'h0, 4'h8, 1, "R8 zero write no effect");
    clear(4'h8, 4'h0, 0, "R8 clear system bit");

    xfer_done = 1; xfer_ioc = 0; step(1, 4'h0, 0, "R3 done without flag");
    xfer_done = 1; xfer_ioc = 1; step(1, 4'h0, 0, "R3 done held");
    ticks(7, 4'h0, 0, "R5 no boundary before 8th tick");
    ticks(1, 4'h1, 1, "R3 released at boundary");
    clear(4'h1, 4'h0, 0, "R8 clear done");

    xfer_err = 1; step(1, 4'h0, 0, "R4 error held");
    ticks(7, 4'h0, 0, "R4 error still pending");
    ticks(1, 4'h2, 1, "R4 error released");
    clear(4'h2, 4'h0, 0, "R8 clear error");

    wb_busy = 1;
    xfer_done = 1; xfer_ioc = 1; step(1, 4'h0, 0, "R7 done with busy write-back");
    ticks(8, 4'h0, 0, "R7 boundary blocked by write-back");
    wb_busy = 0;
    ticks(7, 4'h0, 0, "R7 waits for next boundary");
    ticks(1, 4'h1, 1, "R7 released at later boundary");
    clear(4'h1, 4'h0, 0, "R8 clear done");

    ticks(7, 4'h0, 0, "R11 lead-in");
    uf_tick = 1; xfer_done = 1; xfer_ioc = 1;
    step(1, 4'h0, 0, "R11 arrival on boundary not released");
    ticks(7, 4'h0, 0, "R11 still pending");
    ticks(1, 4'h1, 1, "R11 released one interval later");
    clear(4'h1, 4'h0, 0, "R8 clear done");

    port_chg = 1; clr_wr = 1; clr_data = 4'h4;
    step(1, 4'h4, 1, "R9 set beats clear");
    clear(4'h4, 4'h0, 0, "R8 clear port bit");

    en_wr = 1; en_data = 4'h3; exp_en = 4'h3;
    step(1, 4'h0, 0, "R10 partial enable");
    port_chg = 1; step(1, 4'h4, 0, "R10 disabled port bit visible");
    sys_err = 1;  step(1, 4'hC, 0, "R10 disabled system bit visible");
    en_wr = 1; en_data = 4'hF; exp_en = 4'hF;
    step(1, 4'hC, 1, "R10 enabling raises irq");
    clear(4'hF, 4'h0, 0, "R8 clear all");

    cmd_wr = 1; cmd_thr = 7'd2; exp_thr = 7'd2;
    step(1, 4'h0, 0, "R6 threshold 2 readback");
    xfer_done = 1; xfer_ioc = 1; step(0, 4'h0, 0, "");
    ticks(1, 4'h0, 0, "R6 threshold 2 first tick");
    ticks(1, 4'h1, 1, "R6 threshold 2 boundary");
    clear(4'h1, 4'h0, 0, "R8 clear done");

    cmd_wr = 1; cmd_thr = 7'd3; exp_thr = 7'd8;
    step(1, 4'h0, 0, "R6 illegal value reads 8");
    xfer_done = 1; xfer_ioc = 1; step(0, 4'h0, 0, "");
    ticks(7, 4'h0, 0, "R6 illegal acts as 8");
    ticks(1, 4'h1, 1, "R6 illegal boundary at 8");
    clear(4'h1, 4'h0, 0, "R8 clear done");

    cmd_wr = 1; cmd_thr = 7'd1; exp_thr = 7'd1;
    step(1, 4'h0, 0, "R6 threshold 1 readback");
    xfer_err = 1; step(0, 4'h0, 0, "");
    ticks(1, 4'h2, 1, "R6 threshold 1 every tick");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule